// File: doc/BRIEF.md
# Rounding Shift and Pack Unit

This block performs packed right shifts on 32-bit operands in a single registered stage. It has three kinds of operation. Word pack shifts two 32-bit signed words arithmetically and places the low half of each in one result word. Byte shift applies an arithmetic right shift to four signed bytes. Halfword shift applies a logical right shift to two unsigned halfwords. The word and byte operations can round: when the shift amount is nonzero, the last bit shifted out of a lane is added back into that lane.

The operation is chosen by a 6-bit function code and a 5-bit sub-code. The shift amount comes from a 5-bit immediate field. An accepted operation produces its result on the clock edge that samples `in_valid`, and `out_valid` rises one cycle later. An encoding the block does not recognise produces a zero result.

Top module: `shift_pack_unit`

## Requirements
- R1: While reset is applied and until the first accepted operation, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` equals `in_valid` one cycle earlier. `result` loads only on a cycle with `in_valid` high and holds its value otherwise.
- R3: Word pack (function 6'b010001, sub-code 5'b11110) shifts `src_x` and `src_y` arithmetically right by `shamt[4:0]`. `result[31:16]` takes bits 15:0 of the shifted `src_x`, and `result[15:0]` takes bits 15:0 of the shifted `src_y`.
- R4: Word pack with rounding (function 6'b010001, sub-code 5'b11111) works as R3, but adds 1 to each shifted word when bit `shamt-1` of that unshifted word is 1.
- R5: A shift amount of zero passes every lane through unchanged and adds no rounding, in both the word and the byte operations.
- R6: Byte shift (function 6'b010011, sub-code 5'b00100) shifts each signed byte lane of `src_x` arithmetically right by `shamt[2:0]`. Lane 0 is bits 7:0. `shamt[4:3]` must be 00.
- R7: Byte shift with rounding (function 6'b010011, sub-code 5'b00101) works as R6 and applies the rounding rule of R4 to each lane. Each lane result wraps modulo 256.
- R8: Halfword shift (function 6'b010011, sub-code 5'b11001) shifts each unsigned halfword lane of `src_x` logically right by `shamt[3:0]` and fills with zeros. Lane 0 is bits 15:0. `shamt[4]` must be 0.
- R9: The block produces a zero result and still asserts `out_valid` in three cases: any other function or sub-code, a byte shift whose `shamt[4:3]` is nonzero, or a halfword shift whose `shamt[4]` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation present this cycle |
| fn_code | input | 6 | Function code |
| sub_code | input | 5 | Sub-code selecting the operation and rounding |
| shamt | input | 5 | Immediate shift amount field |
| src_x | input | 32 | Upper word for pack; sole source for byte and halfword shifts |
| src_y | input | 32 | Lower word for pack |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Registered result |

## Verification
The lane assertions check three things: a zero amount passes a lane through unchanged, an arithmetic shift without rounding keeps a lane's sign, and a logical shift never makes a lane larger. These rules hold for any value and any amount, so the stimulus can apply every lane value and every amount freely. The register assertions assume that `in_valid`, the codes and the operands are stable around each rising edge. The bench ensures this by changing all inputs only at the falling edge. The bench sweeps the byte values, amounts and rounding modes exhaustively. For word pack and halfword shift it covers every amount, using the extreme words together with a generated set of other values.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned FN_W  = 6;
  localparam int unsigned SUB_W = 5;
  localparam int unsigned AMT_W = 5;

  localparam logic [FN_W-1:0]  FN_PACK    = 6'b010001;
  localparam logic [FN_W-1:0]  FN_LANE    = 6'b010011;
  localparam logic [SUB_W-1:0] SUB_PACK   = 5'b11110;
  localparam logic [SUB_W-1:0] SUB_PACK_R = 5'b11111;
  localparam logic [SUB_W-1:0] SUB_BYTE   = 5'b00100;
  localparam logic [SUB_W-1:0] SUB_BYTE_R = 5'b00101;
  localparam logic [SUB_W-1:0] SUB_HALF   = 5'b11001;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_PACK = 2'd1,
    SP_BYTE = 2'd2,
    SP_HALF = 2'd3
  } sp_mode_e;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import sp_pkg::*;
(
  input  logic [FN_W-1:0]  fn_code,
  input  logic [SUB_W-1:0] sub_code,
  input  logic [AMT_W-1:0] amt_field,
  output sp_mode_e         mode,
  output logic             round_en
);
  always_comb begin
    mode     = SP_NONE;
    round_en = 1'b0;
    if (fn_code == FN_PACK) begin
      if (sub_code == SUB_PACK) begin
        mode = SP_PACK;
      end else if (sub_code == SUB_PACK_R) begin
        mode     = SP_PACK;
        round_en = 1'b1;
      end
    end else if (fn_code == FN_LANE) begin
      if ((sub_code == SUB_BYTE) && (amt_field[4:3] == 2'b00)) begin
        mode = SP_BYTE;
      end else if ((sub_code == SUB_BYTE_R) && (amt_field[4:3] == 2'b00)) begin
        mode     = SP_BYTE;
        round_en = 1'b1;
      end else if ((sub_code == SUB_HALF) && !amt_field[4]) begin
        mode = SP_HALF;
      end
    end
  end
endmodule

// File: rtl/sp_lane_shr.sv
module sp_lane_shr #(
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 3,
  parameter bit          ARITH = 1'b1,
  parameter int unsigned KEEP  = W
) (
  input  logic [W-1:0]    in_val,
  input  logic [AW-1:0]   amt,
  input  logic            rnd,
  output logic [KEEP-1:0] out_val
);
  logic [W-1:0] shifted;
  logic         inc;
  logic [W-1:0] full;

  generate
    if (ARITH) begin : g_arith
      assign shifted = W'($signed(in_val) >>> amt);
    end else begin : g_logic
      assign shifted = in_val >> amt;
    end
  endgenerate

  always_comb begin
    inc = 1'b0;
    if (rnd && (amt != '0)) begin
      inc = in_val[amt - 1'b1];
    end
  end

  assign full    = shifted + W'(inc);
  assign out_val = full[KEEP-1:0];

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_AMT_PASS: assert (full == in_val); // R5
    end
    if (ARITH && !rnd) begin
      AST_SIGN_KEPT: assert (full[W-1] == in_val[W-1]); // R6
    end
    if (!ARITH) begin
      AST_LOGIC_NO_GROW: assert (full <= in_val); // R8
    end
  end
endmodule

// File: rtl/sp_word_pack.sv
module sp_word_pack #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]         x_word,
  input  logic [DATA_W-1:0]         y_word,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic                      rnd,
  output logic [DATA_W-1:0]         packed_out
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned AW     = $clog2(DATA_W);

  logic [DATA_W-1:0] srcs [2];
  assign srcs[0] = y_word;
  assign srcs[1] = x_word;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_word
      sp_lane_shr #(.W(DATA_W), .AW(AW), .ARITH(1'b1), .KEEP(HALF_W)) u_lane (
        .in_val (srcs[g]),
        .amt    (amt),
        .rnd    (rnd),
        .out_val(packed_out[g*HALF_W +: HALF_W])
      );
    end
  endgenerate
endmodule

// File: rtl/sp_byte_shra.sv
module sp_byte_shra #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        amt,
  input  logic              rnd,
  output logic [DATA_W-1:0] dst
);
  localparam int unsigned LANES = DATA_W / 8;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_byte
      sp_lane_shr #(.W(8), .AW(3), .ARITH(1'b1), .KEEP(8)) u_lane (
        .in_val (src[g*8 +: 8]),
        .amt    (amt),
        .rnd    (rnd),
        .out_val(dst[g*8 +: 8])
      );
    end
  endgenerate
endmodule

// File: rtl/sp_half_shrl.sv
module sp_half_shrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [3:0]        amt,
  output logic [DATA_W-1:0] dst
);
  localparam int unsigned LANES = DATA_W / 16;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_half
      sp_lane_shr #(.W(16), .AW(4), .ARITH(1'b0), .KEEP(16)) u_lane (
        .in_val (src[g*16 +: 16]),
        .amt    (amt),
        .rnd    (1'b0),
        .out_val(dst[g*16 +: 16])
      );
    end
  endgenerate
endmodule

// File: rtl/shift_pack_unit.sv
module shift_pack_unit
  import sp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        fn_code,
  input  logic [4:0]        sub_code,
  input  logic [4:0]        shamt,
  input  logic [DATA_W-1:0] src_x,
  input  logic [DATA_W-1:0] src_y,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int unsigned WAMT_W = $clog2(DATA_W);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sp_mode_e          mode;
  logic              round_en;
  logic [DATA_W-1:0] pack_res;
  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;

  sp_decode u_decode (
    .fn_code  (fn_code),
    .sub_code (sub_code),
    .amt_field(shamt),
    .mode     (mode),
    .round_en (round_en)
  );

  sp_word_pack #(.DATA_W(DATA_W)) u_pack (
    .x_word    (src_x),
    .y_word    (src_y),
    .amt       (shamt[WAMT_W-1:0]),
    .rnd       (round_en),
    .packed_out(pack_res)
  );

  sp_byte_shra #(.DATA_W(DATA_W)) u_byte (
    .src(src_x),
    .amt(shamt[2:0]),
    .rnd(round_en),
    .dst(byte_res)
  );

  sp_half_shrl #(.DATA_W(DATA_W)) u_half (
    .src(src_x),
    .amt(shamt[3:0]),
    .dst(half_res)
  );

  always_comb begin
    case (mode)
      SP_PACK: res_d = pack_res;
      SP_BYTE: res_d = byte_res;
      SP_HALF: res_d = half_res;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result)); // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (mode == SP_NONE)) |=> (result == '0)); // R9
endmodule

// File: tb/shift_pack_unit_tb.sv
module shift_pack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  fn_code = '0;
  logic [4:0]  sub_code = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] src_x = '0;
  logic [31:0] src_y = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  shift_pack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn_code(fn_code),
    .sub_code(sub_code), .shamt(shamt), .src_x(src_x), .src_y(src_y),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [7:0] exp_byte(input logic [7:0] b, input int s, input bit r);
    int v = int'($signed(b));
    int d = 1 << s;
    int rem = ((v % d) + d) % d;
    int q = (v - rem) / d;
    if (r && s != 0 && rem >= d / 2) q = q + 1;
    return q[7:0];
  endfunction

  function automatic logic [15:0] exp_word(input logic [31:0] w, input int s, input bit r);
    longint v = longint'($signed(w));
    longint d = longint'(1) << s;
    longint rem = ((v % d) + d) % d;
    longint q = (v - rem) / d;
    if (r && s != 0 && rem >= d / 2) q = q + 1;
    return q[15:0];
  endfunction

  function automatic logic [15:0] exp_half(input logic [15:0] h, input int s);
    int v = int'(h);
    int q = v / (1 << s);
    return q[15:0];
  endfunction

  task automatic next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic check(input logic [31:0] exp, input logic exp_v, input string tag);
    n_checks++;
    if (result !== exp || out_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               tag, result, out_valid, exp, exp_v);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic run_op(input logic [5:0] f, input logic [4:0] s, input logic [4:0] a,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] exp, input string tag);
    in_valid = 1'b1; fn_code = f; sub_code = s; shamt = a; src_x = x; src_y = y;
    @(negedge clk);
    check(exp, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: result=%h valid=%b expected completion", result, out_valid);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    repeat (3) @(negedge clk);
    check(32'h0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(32'h0, 1'b0, "R1 after reset");

    // R6 / R7 / R5: exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 8; s++) begin
        for (int r = 0; r < 2; r++) begin
          logic [7:0]  b0, b1, b2, b3;
          logic [31:0] x, e;
          b0 = 8'(v); b1 = 8'(v) ^ 8'h5A; b2 = ~8'(v); b3 = 8'(v) + 8'h33;
          x = {b3, b2, b1, b0};
          e = {exp_byte(b3, s, r[0]), exp_byte(b2, s, r[0]),
               exp_byte(b1, s, r[0]), exp_byte(b0, s, r[0])};
          run_op(6'b010011, r[0] ? 5'b00101 : 5'b00100, 5'(s), x, 32'hDEAD_BEEF, e,
                 (s == 0) ? "R5 byte" : (r[0] ? "R7 byte round" : "R6 byte"));
        end
      end
    end

    // R3 / R4 / R5: word pack over every amount
    for (int s = 0; s < 32; s++) begin
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 24; k++) begin
          logic [31:0] x, y, e;
          case (k)
            0: begin x = 32'h8000_0000; y = 32'h7FFF_FFFF; end
            1: begin x = 32'hFFFF_FFFF; y = 32'h0000_0001; end
            2: begin x = 32'h7FFF_FFFF; y = 32'h8000_0000; end
            default: begin next_rand(); x = lcg; next_rand(); y = lcg; end
          endcase
          e = {exp_word(x, s, r[0]), exp_word(y, s, r[0])};
          run_op(6'b010001, r[0] ? 5'b11111 : 5'b11110, 5'(s), x, y, e,
                 (s == 0) ? "R5 pack" : (r[0] ? "R4 pack round" : "R3 pack"));
        end
      end
    end

    // R8: halfword logical shift
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 40; k++) begin
        logic [31:0] x, e;
        if (k == 0) x = 32'hFFFF_8000;
        else if (k == 1) x = 32'h0001_7FFF;
        else begin next_rand(); x = lcg; end
        e = {exp_half(x[31:16], s), exp_half(x[15:0], s)};
        run_op(6'b010011, 5'b11001, 5'(s), x, 32'h0, e, "R8 half");
      end
    end

    // R9: unrecognised encodings give zero
    run_op(6'b010000, 5'b11110, 5'd3, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, "R9 bad function");
    run_op(6'b010011, 5'b11110, 5'd3, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, "R9 bad sub-code");
    run_op(6'b010001, 5'b00100, 5'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R9 byte code under pack function");
    run_op(6'b010011, 5'b00100, 5'b01001, 32'h8080_8080, 32'h0, 32'h0, "R9 byte amount bits set");
    run_op(6'b010011, 5'b00101, 5'b10001, 32'h8080_8080, 32'h0, 32'h0, "R9 round byte amount bits set");
    run_op(6'b010011, 5'b11001, 5'b10011, 32'hFFFF_FFFF, 32'h0, 32'h0, "R9 half amount bit set");

    // R2: hold when idle
    run_op(6'b010011, 5'b11001, 5'd4, 32'hABCD_1234, 32'h0, 32'h0ABC_0123, "R8 half before hold");
    last = 32'h0ABC_0123;
    in_valid = 1'b0; fn_code = 6'b010001; sub_code = 5'b11110; shamt = 5'd0;
    src_x = 32'h5555_5555; src_y = 32'hAAAA_AAAA;
    @(negedge clk);
    check(last, 1'b0, "R2 hold idle cycle 1");
    @(negedge clk);
    check(last, 1'b0, "R2 hold idle cycle 2");
    run_op(6'b010001, 5'b11110, 5'd0, 32'h5555_5555, 32'hAAAA_AAAA, 32'h5555_AAAA, "R2 resume");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule